// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between the load/store port of a pipelined processor and a slow backing memory that moves whole four-word lines. It holds 32 words as eight lines of four words, arranged as four sets of two ways. Hits are answered one cycle after the request. On a miss the processor is stalled while the cache brings in the line, after first writing back a modified victim if one must be evicted.

Stores use write-back with write-allocate. Each set keeps a single recency bit that names its least recently used way. An invalid way is always filled before a valid one is evicted. Two counters record every accepted request and every request that hit on first lookup, so that a hit ratio can be computed from them.

The processor presents a request for one cycle while `req_ready` is high. The memory side raises `mem_req`, with `mem_we` marking a line write, and holds it until the memory answers with a one-cycle `mem_ack`.

Top module: `dcache_2way`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` is 0, `mem_req` is 0, both counters are 0 and no line is valid.
- R2: A request that hits gives `resp_valid`=1 in the cycle after it is accepted. For a load `resp_rdata` is the most recently stored value of that word. For a store it is the stored word.
- R3: A miss whose victim is clean issues one line read (`mem_we`=0) at line address `req_addr[ADDR_W-1:2]`. The response comes 8 clock edges after acceptance when the memory acknowledges on the sixth cycle of `mem_req`.
- R4: The word address splits into offset `[1:0]`, set index `[3:2]` and tag `[ADDR_W-1:4]`. Lines in different sets never displace one another, and at most one way matches a lookup.
- R5: When both ways of a set are valid, a miss evicts the way that was used less recently. Use means a hit or a refill.
- R6: A miss in a set with an invalid way fills that way and keeps the valid line.
- R7: A store hit changes only the addressed word and marks the line modified. Its later eviction writes the whole line back with only that word changed.
- R8: A store miss fetches the line, merges the stored word into it and marks it modified.
- R9: A miss whose victim is modified first writes that line to its own line address (`mem_we`=1), and only then reads the new line. The two transfers never overlap, and the response comes 14 edges after acceptance.
- R10: Evicting an unmodified line causes no memory write.
- R11: `req_ready` is 0 from the edge that accepts a missing request until its response is issued.
- R12: `access_count` rises by one for each accepted request. `hit_count` rises by one for each that hit on first lookup, so it never exceeds `access_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present (one cycle, while req_ready) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W (32) | Word address |
| req_wdata | input | DATA_W (32) | Store data |
| req_ready | output | 1 | Cache can accept a request |
| resp_valid | output | 1 | Response data valid |
| resp_rdata | output | DATA_W (32) | Response word |
| mem_req | output | 1 | Line transfer requested |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W-2 (30) | Line address |
| mem_wline | output | 4*DATA_W (128) | Line written back, word k at bits [32k+31:32k] |
| mem_rline | input | 4*DATA_W (128) | Line read, same word order, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the current transfer |
| hit_count | output | CNT_W (32) | First-lookup hits |
| access_count | output | CNT_W (32) | Accepted requests |

## Verification
A hit's response is due one edge after the accepting edge. A clean miss is due after 8 edges: six of line read, one install and one reply. A dirty miss is due after 14, because a six-cycle write-back comes first. Each scenario task drives the request half a cycle before the accepting edge and samples 1 ns after each following edge. It counts edges until `resp_valid` appears, and compares that count with 1, 8 or 14 as computed from the expected contents and recency state of the set. Memory-side effects, such as write-back address, written data and read count, are checked once the response has arrived, when all transfers for that request have finished.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [1:0] {
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL,
    ST_REPLY
  } cstate_e;

  // Victim choice for a two-way set: an empty way first, else the LRU way.
  function automatic logic pick_victim(input logic [1:0] valid, input logic lru);
    if (!valid[0]) return 1'b0;
    if (!valid[1]) return 1'b1;
    return lru;
  endfunction

endpackage

// File: rtl/dcache_tags.sv
module dcache_tags #(
  parameter int TAG_W   = 28,
  parameter int INDEX_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [INDEX_W-1:0]         lk_index,
  input  logic [TAG_W-1:0]           lk_tag,
  output logic [1:0]                 way_hit,
  output logic [1:0]                 way_valid,
  output logic [1:0]                 way_dirty,
  output logic [1:0][TAG_W-1:0]      way_tag,
  output logic                       lru_way,
  input  logic                       touch_en,
  input  logic [INDEX_W-1:0]         touch_index,
  input  logic                       touch_way,
  input  logic                       dirty_en,
  input  logic [INDEX_W-1:0]         dirty_index,
  input  logic                       dirty_way,
  input  logic                       fill_en,
  input  logic [INDEX_W-1:0]         fill_index,
  input  logic                       fill_way,
  input  logic [TAG_W-1:0]           fill_tag,
  input  logic                       fill_dirty
);
  localparam int SETS = 1 << INDEX_W;

  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == 1'(w)) tag_q[fill_index] <= fill_tag;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else if (fill_en && fill_way == 1'(w)) begin
        valid_q[fill_index] <= 1'b1;
        dirty_q[fill_index] <= fill_dirty;
      end else if (dirty_en && dirty_way == 1'(w)) begin
        dirty_q[dirty_index] <= 1'b1;
      end
    end

    assign way_valid[w] = valid_q[lk_index];
    assign way_dirty[w] = dirty_q[lk_index];
    assign way_tag[w]   = tag_q[lk_index];
    assign way_hit[w]   = valid_q[lk_index] && (tag_q[lk_index] == lk_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lru_q <= '0;
    else if (touch_en) lru_q[touch_index] <= ~touch_way;
  end

  assign lru_way = lru_q[lk_index];

  // R5: after a use, the recency bit of that set names the other way
  p_lru_touch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> lru_q[$past(touch_index)] != $past(touch_way));

endmodule

// File: rtl/dcache_lines.sv
module dcache_lines #(
  parameter int DATA_W   = 32,
  parameter int OFFSET_W = 2,
  parameter int INDEX_W  = 2
) (
  input  logic                                      clk,
  input  logic [INDEX_W-1:0]                        rd_index,
  output logic [1:0][(DATA_W<<OFFSET_W)-1:0]        rd_line,
  input  logic                                      wr_word_en,
  input  logic [INDEX_W-1:0]                        wr_index,
  input  logic                                      wr_way,
  input  logic [OFFSET_W-1:0]                       wr_offset,
  input  logic [DATA_W-1:0]                         wr_word,
  input  logic                                      fill_en,
  input  logic [INDEX_W-1:0]                        fill_index,
  input  logic                                      fill_way,
  input  logic [(DATA_W<<OFFSET_W)-1:0]             fill_line
);
  localparam int SETS   = 1 << INDEX_W;
  localparam int LINE_W = DATA_W << OFFSET_W;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [LINE_W-1:0] line_q [SETS];

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == 1'(w))
        line_q[fill_index] <= fill_line;
      else if (wr_word_en && wr_way == 1'(w))
        line_q[wr_index][wr_offset*DATA_W +: DATA_W] <= wr_word;
    end

    assign rd_line[w] = line_q[rd_index];
  end

endmodule

// File: rtl/dcache_stat_ctr.sv
module dcache_stat_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/dcache_2way.sv
module dcache_2way
  import dcache_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int OFFSET_W = 2,
  parameter int INDEX_W  = 2,
  parameter int CNT_W    = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic                              req_write,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [DATA_W-1:0]                 req_wdata,
  output logic                              req_ready,
  output logic                              resp_valid,
  output logic [DATA_W-1:0]                 resp_rdata,
  output logic                              mem_req,
  output logic                              mem_we,
  output logic [ADDR_W-OFFSET_W-1:0]        mem_addr,
  output logic [(DATA_W<<OFFSET_W)-1:0]     mem_wline,
  input  logic [(DATA_W<<OFFSET_W)-1:0]     mem_rline,
  input  logic                              mem_ack,
  output logic [CNT_W-1:0]                  hit_count,
  output logic [CNT_W-1:0]                  access_count
);
  localparam int LINE_W  = DATA_W << OFFSET_W;
  localparam int TAG_W   = ADDR_W - OFFSET_W - INDEX_W;
  localparam int LADDR_W = ADDR_W - OFFSET_W;

  function automatic logic [DATA_W-1:0] word_of(input logic [LINE_W-1:0] line,
                                                input logic [OFFSET_W-1:0] off);
    return line[off*DATA_W +: DATA_W];
  endfunction

  function automatic logic [LINE_W-1:0] merge_store(input logic [LINE_W-1:0] line,
                                                    input logic en,
                                                    input logic [OFFSET_W-1:0] off,
                                                    input logic [DATA_W-1:0] word);
    logic [LINE_W-1:0] r;
    r = line;
    if (en) r[off*DATA_W +: DATA_W] = word;
    return r;
  endfunction

  cstate_e state;

  logic                  sv_write;
  logic [ADDR_W-1:0]     sv_addr;
  logic [DATA_W-1:0]     sv_wdata;
  logic                  victim_way;
  logic [TAG_W-1:0]      victim_tag;

  logic [OFFSET_W-1:0]   req_off, sv_off;
  logic [INDEX_W-1:0]    req_idx, sv_idx, lk_index;
  logic [TAG_W-1:0]      req_tag, sv_tag;

  assign req_off = req_addr[OFFSET_W-1:0];
  assign req_idx = req_addr[OFFSET_W +: INDEX_W];
  assign req_tag = req_addr[ADDR_W-1:OFFSET_W+INDEX_W];
  assign sv_off  = sv_addr[OFFSET_W-1:0];
  assign sv_idx  = sv_addr[OFFSET_W +: INDEX_W];
  assign sv_tag  = sv_addr[ADDR_W-1:OFFSET_W+INDEX_W];

  assign lk_index = (state == ST_LOOKUP) ? req_idx : sv_idx;

  logic [1:0]              way_hit, way_valid, way_dirty;
  logic [1:0][TAG_W-1:0]   way_tag;
  logic                    lru_way;
  logic [1:0][LINE_W-1:0]  rd_line;

  // Named internal events
  logic accept, ev_hit, ev_miss, ev_fill, ev_wb_done, hit_way, vict;
  assign req_ready  = (state == ST_LOOKUP);
  assign accept     = req_valid && req_ready;
  assign ev_hit     = accept && (|way_hit);
  assign ev_miss    = accept && !(|way_hit);
  assign ev_fill    = (state == ST_FILL) && mem_ack;
  assign ev_wb_done = (state == ST_EVICT) && mem_ack;
  assign hit_way    = way_hit[1];
  assign vict       = pick_victim(way_valid, lru_way);

  dcache_tags #(.TAG_W(TAG_W), .INDEX_W(INDEX_W)) u_tags (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_index    (lk_index),
    .lk_tag      (req_tag),
    .way_hit     (way_hit),
    .way_valid   (way_valid),
    .way_dirty   (way_dirty),
    .way_tag     (way_tag),
    .lru_way     (lru_way),
    .touch_en    (ev_hit || ev_fill),
    .touch_index (ev_hit ? req_idx : sv_idx),
    .touch_way   (ev_hit ? hit_way : victim_way),
    .dirty_en    (ev_hit && req_write),
    .dirty_index (req_idx),
    .dirty_way   (hit_way),
    .fill_en     (ev_fill),
    .fill_index  (sv_idx),
    .fill_way    (victim_way),
    .fill_tag    (sv_tag),
    .fill_dirty  (sv_write)
  );

  dcache_lines #(.DATA_W(DATA_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W)) u_lines (
    .clk        (clk),
    .rd_index   (lk_index),
    .rd_line    (rd_line),
    .wr_word_en (ev_hit && req_write),
    .wr_index   (req_idx),
    .wr_way     (hit_way),
    .wr_offset  (req_off),
    .wr_word    (req_wdata),
    .fill_en    (ev_fill),
    .fill_index (sv_idx),
    .fill_way   (victim_way),
    .fill_line  (merge_store(mem_rline, sv_write, sv_off, sv_wdata))
  );

  dcache_stat_ctr #(.W(CNT_W)) u_acc_ctr (
    .clk (clk), .rst_n (rst_n), .inc (accept), .count (access_count)
  );

  dcache_stat_ctr #(.W(CNT_W)) u_hit_ctr (
    .clk (clk), .rst_n (rst_n), .inc (ev_hit), .count (hit_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_LOOKUP;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      sv_write   <= 1'b0;
      sv_addr    <= '0;
      sv_wdata   <= '0;
      victim_way <= 1'b0;
      victim_tag <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state)
        ST_LOOKUP: begin
          if (ev_hit) begin
            resp_valid <= 1'b1;
            resp_rdata <= req_write ? req_wdata : word_of(rd_line[hit_way], req_off);
          end else if (ev_miss) begin
            sv_write   <= req_write;
            sv_addr    <= req_addr;
            sv_wdata   <= req_wdata;
            victim_way <= vict;
            victim_tag <= way_tag[vict];
            state      <= (way_valid[vict] && way_dirty[vict]) ? ST_EVICT : ST_FILL;
          end
        end
        ST_EVICT: if (mem_ack) state <= ST_FILL;
        ST_FILL:  if (mem_ack) state <= ST_REPLY;
        ST_REPLY: begin
          resp_valid <= 1'b1;
          resp_rdata <= word_of(rd_line[victim_way], sv_off);
          state      <= ST_LOOKUP;
        end
        default: state <= ST_LOOKUP;
      endcase
    end
  end

  assign mem_req   = (state == ST_EVICT) || (state == ST_FILL);
  assign mem_we    = (state == ST_EVICT);
  assign mem_addr  = (state == ST_EVICT) ? LADDR_W'({victim_tag, sv_idx})
                                         : sv_addr[ADDR_W-1:OFFSET_W];
  assign mem_wline = rd_line[victim_way];

  // R2: a first-lookup hit answers on the next cycle
  p_hit_reply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> resp_valid);

  // R4: a lookup never matches both ways
  p_one_way_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  // R9: write-back completion is followed by a line read, not overlapped
  p_evict_then_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_done |=> (mem_req && !mem_we));

  // R8: an installed line is answered one cycle after the install
  p_fill_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> !req_ready ##1 resp_valid);

  // R11: a missing request stalls the requester
  p_miss_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> !req_ready);

  // R12: hits never outnumber accesses
  p_counts_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count <= access_count);

endmodule

// File: tb/dcache_2way_test.sv
`timescale 1ns/1ps
module dcache_2way_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]  req_addr = '0, req_wdata = '0;
  logic         req_ready, resp_valid;
  logic [31:0]  resp_rdata;
  logic         mem_req, mem_we, mem_ack;
  logic [29:0]  mem_addr;
  logic [127:0] mem_wline, mem_rline;
  logic [31:0]  hit_count, access_count;

  always #10 clk = ~clk;

  dcache_2way uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wline(mem_wline),
    .mem_rline(mem_rline), .mem_ack(mem_ack), .hit_count(hit_count),
    .access_count(access_count)
  );

  // Backing memory: 256 words, acknowledges on the sixth cycle of a request
  logic [31:0] bmem [256];
  logic [31:0] shadow [256];
  int mcnt = 0, rd_cnt = 0, wb_cnt = 0;
  logic [29:0] last_rd = '0, last_wb = '0;

  assign mem_ack = mem_req && (mcnt == 5);

  always_comb begin
    for (int k = 0; k < 4; k++) mem_rline[k*32 +: 32] = bmem[{mem_addr[5:0], 2'(k)}];
  end

  always @(posedge clk) begin
    if (!rst_n) mcnt <= 0;
    else if (mem_ack) begin
      mcnt <= 0;
      if (mem_we) begin
        for (int k = 0; k < 4; k++) bmem[{mem_addr[5:0], 2'(k)}] <= mem_wline[k*32 +: 32];
        wb_cnt  <= wb_cnt + 1;
        last_wb <= mem_addr;
      end else begin
        rd_cnt  <= rd_cnt + 1;
        last_rd <= mem_addr;
      end
    end else if (mem_req) mcnt <= mcnt + 1;
  end

  int checks = 0, fails = 0, exp_acc = 0, exp_hit = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run_access(input logic wr, input logic [31:0] addr,
                            input logic [31:0] wd, input int exp_lat, input string rq);
    int n;
    logic [31:0] exp;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    if (wr) shadow[addr[7:0]] = wd;
    exp = shadow[addr[7:0]];
    exp_acc++;
    if (exp_lat == 1) exp_hit++;
    @(posedge clk); #1;
    req_valid = 1'b0;
    n = 1;
    if (exp_lat > 1) chk(req_ready == 1'b0, "R11", "ready during miss", 32'(req_ready), 32'd0);
    while (!resp_valid && n < 40) begin
      @(posedge clk); #1; n++;
    end
    chk(n == exp_lat, rq, "latency", n, exp_lat);
    chk(resp_rdata == exp, rq, "data", resp_rdata, exp);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'd1);
    chk(resp_valid == 1'b0, "R1", "resp_valid", 32'(resp_valid), 32'd0);
    chk(mem_req == 1'b0, "R1", "mem_req", 32'(mem_req), 32'd0);
    chk(access_count == 0, "R1", "access_count", access_count, 32'd0);
    chk(hit_count == 0, "R1", "hit_count", hit_count, 32'd0);
  endtask

  task automatic t_clean_fill();
    run_access(1'b0, 32'h01, '0, 8, "R3");
    chk(rd_cnt == 1, "R3", "line reads", rd_cnt, 32'd1);
    chk(last_rd == 30'h0, "R3", "read line address", 32'(last_rd), 32'h0);
    run_access(1'b0, 32'h02, '0, 1, "R2");
  endtask

  task automatic t_invalid_first();
    run_access(1'b0, 32'h13, '0, 8, "R6");
    chk(last_rd == 30'h4, "R3", "read line address", 32'(last_rd), 32'h4);
    run_access(1'b0, 32'h00, '0, 1, "R6");
  endtask

  task automatic t_store_hit();
    run_access(1'b1, 32'h11, 32'hBEEF_0011, 1, "R7");
    run_access(1'b0, 32'h11, '0, 1, "R2");
  endtask

  task automatic t_lru_order();
    run_access(1'b0, 32'h20, '0, 8, "R5");   // evicts clean line 0x00
    chk(wb_cnt == 0, "R10", "write-backs", wb_cnt, 32'd0);
    run_access(1'b0, 32'h12, '0, 1, "R5");   // dirty line kept
    run_access(1'b0, 32'h01, '0, 8, "R5");   // evicts clean line 0x20
    chk(wb_cnt == 0, "R10", "write-backs", wb_cnt, 32'd0);
  endtask

  task automatic t_dirty_evict();
    run_access(1'b0, 32'h30, '0, 14, "R9");
    chk(wb_cnt == 1, "R9", "write-backs", wb_cnt, 32'd1);
    chk(last_wb == 30'h4, "R9", "write-back line address", 32'(last_wb), 32'h4);
    chk(bmem[8'h11] == 32'hBEEF_0011, "R7", "stored word in memory", bmem[8'h11], 32'hBEEF_0011);
    chk(bmem[8'h10] == 32'hC0DE_0010, "R7", "neighbour word in memory", bmem[8'h10], 32'hC0DE_0010);
    chk(rd_cnt == 5, "R9", "line reads", rd_cnt, 32'd5);
  endtask

  task automatic t_write_allocate();
    run_access(1'b1, 32'h25, 32'h5A5A_0025, 8, "R8");
    run_access(1'b0, 32'h25, '0, 1, "R8");
    run_access(1'b0, 32'h24, '0, 1, "R8");
    run_access(1'b0, 32'h05, '0, 8, "R6");
    run_access(1'b0, 32'h15, '0, 14, "R8");
    chk(last_wb == 30'h9, "R8", "write-back line address", 32'(last_wb), 32'h9);
    chk(bmem[8'h25] == 32'h5A5A_0025, "R8", "merged word in memory", bmem[8'h25], 32'h5A5A_0025);
  endtask

  task automatic t_set_isolation();
    run_access(1'b0, 32'h30, '0, 1, "R4");
    run_access(1'b0, 32'h03, '0, 1, "R4");
  endtask

  task automatic t_counters();
    chk(access_count == 32'(exp_acc), "R12", "access_count", access_count, 32'(exp_acc));
    chk(hit_count == 32'(exp_hit), "R12", "hit_count", hit_count, 32'(exp_hit));
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin
      bmem[a]   = 32'hC0DE_0000 | 32'(a);
      shadow[a] = 32'hC0DE_0000 | 32'(a);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean_fill();
    t_invalid_first();
    t_store_hit();
    t_lru_order();
    t_dirty_evict();
    t_write_allocate();
    t_set_isolation();
    t_counters();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule